// File: doc/BRIEF.md
# Flash Command Launch Validator

This block is the command front end of a flash memory controller. Software fills a small file of 16-bit parameter words. Each write names a slot index, and the index of the last write is kept. Software then starts a command by writing a one to the command-done flag, which clears it. At that edge the block checks the words against the launch rules. If a rule fails, it raises the access-error bit and does not start the command. Otherwise it holds the done flag low for a fixed number of busy cycles. When the done flag rises again, the effect of the command is applied.

Two commands are handled. The key verification command compares four supplied words with a stored backdoor key. A correct key opens the unlock output. Any mismatch locks out every later attempt until reset. The margin command stores a read margin level for one flash block. Each block has its own stored level, and the level of the block selected on the read side is shown on an output.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, done_flag is 1, acc_err is 0, key_unlocked is 0, and every block's margin level reads 0 (normal).
- R2: A launch happens when done_clr is 1 while done_flag is 1 and acc_err is 0. If the command is accepted, done_flag goes low at that edge and stays low for exactly BUSY_CYC cycles. If the command is rejected, acc_err is set at that edge and done_flag stays 1.
- R3: For the key verification command (word 0 bits [15:8] = 8'h0C), acc_err is set if the last written index is not 3'b100.
- R4: The key verification command sets acc_err if load_active is 1 at launch.
- R5: The key verification command sets acc_err unless key_en equals 2'b10.
- R6: The key verification command sets acc_err when any of words 1 to 4 differs from KEY[63:48], KEY[47:32], KEY[31:16] and KEY[15:0], compared in that order. When all checks pass, key_unlocked becomes 1 as done_flag rises and stays 1 until reset.
- R7: After any key mismatch, every later key verification sets acc_err, even with the correct key, until reset.
- R8: The margin command (word 0 bits [15:8] = 8'h0D) takes the block number from word 0 bits [6:0] and the level from word 1. The valid levels are 0 (normal), 1 (erased-side margin) and 2 (programmed-side margin). The level is stored for that block only as done_flag rises, and rd_margin shows the level of block rd_blk.
- R9: A margin level above 2, or a block number of NBLK or more, sets acc_err and leaves every stored level unchanged.
- R10: Writing a one to err_clr clears acc_err. A launch attempt while acc_err is 1 is ignored, and that includes an attempt in the same cycle as the clear.
- R11: Parameter writes made while done_flag is 0 change neither the slots nor the index.
- R12: Any other opcode in word 0 bits [15:8] sets acc_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Parameter word write strobe |
| wr_idx | input | 3 | Slot index of the write; it becomes the last written index |
| wr_data | input | 16 | Parameter word data |
| done_clr | input | 1 | Writing a one clears done_flag, which starts a command |
| err_clr | input | 1 | Writing a one clears acc_err |
| load_active | input | 1 | A load-data-field sequence is in progress |
| key_en | input | 2 | Backdoor enable field; only 2'b10 enables key access |
| rd_blk | input | BLK_W | Block whose margin level is shown |
| done_flag | output | 1 | Command done / idle flag |
| acc_err | output | 1 | Access error status |
| key_unlocked | output | 1 | Backdoor key accepted |
| rd_margin | output | 2 | Margin level of block rd_blk |

## Verification
Two events can share an edge. The first pair is a launch request and an error clear. The bench drives done_clr and err_clr high together while acc_err is set. It then expects acc_err low, done_flag still high, and no busy period. The second pair is a busy period and parameter writes. The bench writes new words while a margin command is busy and then launches again without rewriting. The stored level must still match the value written before the first launch.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef logic [15:0] word_t;

    localparam logic [7:0] OPC_KEY_VERIFY = 8'h0C;
    localparam logic [7:0] OPC_SET_MARGIN = 8'h0D;
    localparam logic [1:0] KEY_ACCESS_ON  = 2'b10;
    localparam logic [2:0] KEY_LAST_IDX   = 3'b100;

    typedef enum logic [1:0] {
        MRG_NORMAL = 2'd0,
        MRG_ERASED = 2'd1,
        MRG_PROG   = 2'd2
    } margin_e;

    typedef struct packed {
        logic       reject;
        logic       do_verify;
        logic       do_margin;
        logic       key_miss;
        logic [6:0] blk;
        margin_e    lvl;
    } launch_res_t;

    function automatic logic level_ok(input word_t w);
        return w <= 16'd2;
    endfunction

endpackage

// File: rtl/flash_prm_regs.sv
module flash_prm_regs
    import flash_cmd_pkg::*;
#(
    parameter int NWORD = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     busy,
    input  logic                     wr_en,
    input  logic [2:0]               wr_idx,
    input  word_t                    wr_data,
    output logic [2:0]               last_idx,
    output logic [NWORD-1:0][15:0]   words
);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_idx <= '0;
        end else if (wr_en && !busy) begin
            last_idx <= wr_idx;
        end
    end

    for (genvar s = 0; s < NWORD; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                words[s] <= '0;
            end else if (wr_en && !busy && (wr_idx == 3'(s))) begin
                words[s] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_check.sv
module flash_cmd_check
    import flash_cmd_pkg::*;
#(
    parameter int          NWORD = 5,
    parameter int          NBLK  = 4,
    parameter logic [63:0] KEY   = 64'hA5A5_1234_5678_C3C3
) (
    input  logic [NWORD-1:0][15:0] words,
    input  logic [2:0]             last_idx,
    input  logic                   load_active,
    input  logic [1:0]             key_en,
    input  logic                   miss_seen,
    output launch_res_t            res
);

    logic [7:0] opc;
    logic       key_diff;

    assign opc = words[0][15:8];

    always_comb begin
        key_diff = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            if (words[k] != KEY[16*(4-k) +: 16]) key_diff = 1'b1;
        end
    end

    always_comb begin
        res           = '0;
        res.blk       = words[0][6:0];
        res.lvl       = margin_e'(words[1][1:0]);
        if (opc == OPC_KEY_VERIFY) begin
            res.key_miss  = key_diff;
            res.reject    = (last_idx != KEY_LAST_IDX) || load_active ||
                            (key_en != KEY_ACCESS_ON) || key_diff || miss_seen;
            res.do_verify = !res.reject;
        end else if (opc == OPC_SET_MARGIN) begin
            res.reject    = (32'(words[0][6:0]) >= NBLK) || !level_ok(words[1]);
            res.do_margin = !res.reject;
        end else begin
            res.reject    = 1'b1;
        end
    end

endmodule

// File: rtl/flash_margin_tbl.sv
module flash_margin_tbl
    import flash_cmd_pkg::*;
#(
    parameter int NBLK  = 4,
    parameter int BLK_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [6:0]       wr_blk,
    input  margin_e          wr_lvl,
    input  logic [BLK_W-1:0] rd_blk,
    output margin_e          rd_lvl
);

    margin_e lvl_q [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q[b] <= MRG_NORMAL;
            end else if (wr_en && (wr_blk == 7'(b))) begin
                lvl_q[b] <= wr_lvl;
            end
        end
    end

    always_comb begin
        rd_lvl = MRG_NORMAL;
        for (int b = 0; b < NBLK; b++) begin
            if (32'(rd_blk) == b) rd_lvl = lvl_q[b];
        end
    end

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
    import flash_cmd_pkg::*;
#(
    parameter int          NWORD    = 5,
    parameter int          NBLK     = 4,
    parameter int          BUSY_CYC = 3,
    parameter logic [63:0] KEY      = 64'hA5A5_1234_5678_C3C3,
    localparam int         BLK_W    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_idx,
    input  logic [15:0]      wr_data,
    input  logic             done_clr,
    input  logic             err_clr,
    input  logic             load_active,
    input  logic [1:0]       key_en,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             done_flag,
    output logic             acc_err,
    output logic             key_unlocked,
    output logic [1:0]       rd_margin
);

    localparam int CW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

    logic [2:0]             last_idx;
    logic [NWORD-1:0][15:0] words;
    launch_res_t            res;
    launch_res_t            pend_q;
    logic                   miss_q;
    logic [CW-1:0]          cnt_q;
    logic                   launch;
    logic                   finish;
    margin_e                rd_lvl;

    assign launch = done_clr && done_flag && !acc_err;
    assign finish = !done_flag && (cnt_q == '0);

    flash_prm_regs #(.NWORD(NWORD)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .busy     (!done_flag),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .last_idx (last_idx),
        .words    (words)
    );

    flash_cmd_check #(.NWORD(NWORD), .NBLK(NBLK), .KEY(KEY)) u_check (
        .words       (words),
        .last_idx    (last_idx),
        .load_active (load_active),
        .key_en      (key_en),
        .miss_seen   (miss_q),
        .res         (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag    <= 1'b1;
            acc_err      <= 1'b0;
            miss_q       <= 1'b0;
            key_unlocked <= 1'b0;
            cnt_q        <= '0;
            pend_q       <= '0;
        end else begin
            if (err_clr) acc_err <= 1'b0;
            if (launch) begin
                if (res.key_miss) miss_q <= 1'b1;
                if (res.reject) begin
                    acc_err <= 1'b1;
                end else begin
                    done_flag <= 1'b0;
                    cnt_q     <= CW'(BUSY_CYC - 1);
                    pend_q    <= res;
                end
            end else if (finish) begin
                done_flag <= 1'b1;
                if (pend_q.do_verify) key_unlocked <= 1'b1;
            end else if (!done_flag) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    flash_margin_tbl #(.NBLK(NBLK), .BLK_W(BLK_W)) u_margin (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (finish && pend_q.do_margin),
        .wr_blk (pend_q.blk),
        .wr_lvl (pend_q.lvl),
        .rd_blk (rd_blk),
        .rd_lvl (rd_lvl)
    );

    assign rd_margin = rd_lvl;

endmodule

// File: rtl/flash_cmd_front_chk.sv
module flash_cmd_front_chk #(
    parameter int BLK_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             done_clr,
    input logic             err_clr,
    input logic             done_flag,
    input logic             acc_err,
    input logic             key_unlocked,
    input logic [BLK_W-1:0] rd_blk,
    input logic [1:0]       rd_margin
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $fell(rst) |-> (done_flag && !acc_err && !key_unlocked));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done_flag) |-> ($past(done_clr) && !$past(acc_err)));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_err && !err_clr) |=> acc_err);

    // R10
    blocked_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_err && done_flag) |=> done_flag);

    // R2
    err_at_launch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_err) |-> ($past(done_flag) && $past(done_clr)));

    // R6
    unlock_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(key_unlocked) |-> $rose(done_flag));

    // R9
    margin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(rd_blk) && !$rose(done_flag)) |-> $stable(rd_margin));

    // R8
    margin_code_chk: assert property (@(posedge clk) disable iff (rst)
        rd_margin != 2'd3);

endmodule

bind flash_cmd_front flash_cmd_front_chk #(.BLK_W(BLK_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .done_clr     (done_clr),
    .err_clr      (err_clr),
    .done_flag    (done_flag),
    .acc_err      (acc_err),
    .key_unlocked (key_unlocked),
    .rd_blk       (rd_blk),
    .rd_margin    (rd_margin)
);

// File: tb/flash_cmd_front_test.sv
module flash_cmd_front_test;

    localparam int          NBLK = 4;
    localparam int          BUSY = 3;
    localparam logic [63:0] KEYV = 64'h1357_9BDF_2468_ACE0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        done_clr = 1'b0;
    logic        err_clr = 1'b0;
    logic        load_active = 1'b0;
    logic [1:0]  key_en = 2'b10;
    logic [1:0]  rd_blk = '0;
    logic        done_flag, acc_err, key_unlocked;
    logic [1:0]  rd_margin;

    int checks = 0;
    int errors = 0;
    int mexp [NBLK];

    always #4 clk = ~clk;

    flash_cmd_front #(.NWORD(5), .NBLK(NBLK), .BUSY_CYC(BUSY), .KEY(KEYV)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .done_clr(done_clr), .err_clr(err_clr), .load_active(load_active),
        .key_en(key_en), .rd_blk(rd_blk), .done_flag(done_flag), .acc_err(acc_err),
        .key_unlocked(key_unlocked), .rd_margin(rd_margin)
    );

    // {block[6:0], level[15:0], expect_error}
    localparam logic [23:0] VEC [7] = '{
        {7'd1, 16'd2, 1'b0},
        {7'd3, 16'd1, 1'b0},
        {7'd4, 16'd1, 1'b1},
        {7'd2, 16'd3, 1'b1},
        {7'd0, 16'd2, 1'b0},
        {7'd1, 16'd1, 1'b0},
        {7'd2, 16'hFFFF, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    // launch, then return the observed busy length (0 when rejected)
    task automatic run(output int busy_len, output logic err);
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        err = acc_err;
        busy_len = 0;
        while (!done_flag && busy_len < 50) begin
            @(negedge clk);
            busy_len++;
        end
    endtask

    task automatic chk_margins(input string req);
        for (int b = 0; b < NBLK; b++) begin
            rd_blk = 2'(b);
            #1;
            chk(req, int'(rd_margin), mexp[b]);
        end
    endtask

    task automatic load_key(input logic [63:0] k);
        wr(3'd0, 16'h0C00);
        wr(3'd1, k[63:48]);
        wr(3'd2, k[47:32]);
        wr(3'd3, k[31:16]);
        wr(3'd4, k[15:0]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < NBLK; b++) mexp[b] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int   n;
        logic e;
        do_reset();
        // R1 reset state
        chk("R1 done", done_flag, 1);
        chk("R1 err", acc_err, 0);
        chk("R1 unlock", key_unlocked, 0);
        chk_margins("R1 margin");

        // R8 / R9 / R2 vector walk over margin commands
        foreach (VEC[v]) begin
            wr(3'd0, {8'h0D, 1'b0, VEC[v][23:17]});
            wr(3'd1, VEC[v][16:1]);
            run(n, e);
            chk("R9 err", e, VEC[v][0]);
            chk("R2 busy", n, VEC[v][0] ? 0 : BUSY);
            if (!VEC[v][0]) mexp[VEC[v][23:17]] = int'(VEC[v][16:1]);
            if (e) pulse_clr();
            chk_margins("R8 levels");
        end

        // R12 unknown opcode
        wr(3'd0, 16'h0500);
        run(n, e);
        chk("R12 err", e, 1);
        chk("R12 busy", n, 0);

        // R10 launch while error is ignored
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        chk("R10 done stays", done_flag, 1);
        chk("R10 err stays", acc_err, 1);
        // R10 clear and launch in the same cycle: clear wins, launch ignored
        wr(3'd0, {8'h0D, 8'd2});
        wr(3'd1, 16'd1);
        @(negedge clk); done_clr = 1'b1; err_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0; err_clr = 1'b0;
        chk("R10 cleared", acc_err, 0);
        chk("R10 no launch", done_flag, 1);
        chk_margins("R10 no effect");

        // R11 writes during busy are ignored
        wr(3'd0, {8'h0D, 8'd3});
        wr(3'd1, 16'd2);
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        wr_en = 1'b1; wr_idx = 3'd1; wr_data = 16'd0;
        @(negedge clk);
        wr_idx = 3'd0; wr_data = {8'h0D, 8'd0};
        @(negedge clk);
        wr_en = 1'b0;
        repeat (BUSY) @(negedge clk);
        chk("R11 done", done_flag, 1);
        mexp[3] = 2;
        run(n, e);
        chk("R11 rerun ok", e, 0);
        chk_margins("R11 old words");

        // key verification
        key_en = 2'b10;
        // R3 last index not 4
        load_key(KEYV);
        wr(3'd2, KEYV[47:32]);
        run(n, e);
        chk("R3 err", e, 1);
        pulse_clr();
        // R4 load sequence active
        load_key(KEYV);
        load_active = 1'b1;
        run(n, e);
        load_active = 1'b0;
        chk("R4 err", e, 1);
        pulse_clr();
        // R5 enable field
        key_en = 2'b01;
        run(n, e);
        chk("R5 err 01", e, 1);
        pulse_clr();
        key_en = 2'b11;
        run(n, e);
        chk("R5 err 11", e, 1);
        pulse_clr();
        key_en = 2'b10;
        chk("R5 still locked", key_unlocked, 0);
        // R6 correct key opens
        run(n, e);
        chk("R6 ok", e, 0);
        chk("R6 busy", n, BUSY);
        chk("R6 unlocked", key_unlocked, 1);

        // R7 sticky mismatch
        do_reset();
        chk("R1 unlock after reset", key_unlocked, 0);
        chk_margins("R1 margins after reset");
        load_key(KEYV ^ 64'h0000_0000_0001_0000);
        run(n, e);
        chk("R6 wrong key", e, 1);
        chk("R6 wrong key locked", key_unlocked, 0);
        pulse_clr();
        load_key(KEYV);
        run(n, e);
        chk("R7 sticky", e, 1);
        chk("R7 locked", key_unlocked, 0);
        pulse_clr();
        do_reset();
        load_key(KEYV);
        run(n, e);
        chk("R7 reset frees", e, 0);
        chk("R7 unlocked", key_unlocked, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule